// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers interrupt events from five sources of a peripheral chip: the underflow of two timers, a time-of-day alarm, the serial port and an external flag input. Each source delivers a one-cycle event pulse. The block stores each pulse in a status flag. It holds an enable mask and drives an active-low interrupt request line while any enabled source has a pending flag.

Software reaches the block through one register on a small bus. A write changes the enable mask. The top data bit of the write picks the mode: every lower bit written as 1 is either set or cleared in the mask, and every bit written as 0 keeps its old value. A read returns the pending flags together with a summary request bit. The read also clears all flags. An event that lands in the same cycle as that read survives the clear.

Top module: `irq_mask_ctrl`

## Requirements
- R1: Synchronous active-high reset clears all mask bits and all flags. After reset `irq_n` is 1 and `bus_rdata` is 0x00.
- R2: A 1 on `evt_in[i]` for one cycle sets flag i, whatever the mask holds. The flag stays set until a read. The flags appear at read bits 4..0 in this order: bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 flag pin. `evt_in[i]` feeds bit i.
- R3: On a write with data bit 7 = 1, each mask bit i (i = 0..4) whose data bit i is 1 becomes 1.
- R4: On a write with data bit 7 = 0, each mask bit i whose data bit i is 1 becomes 0.
- R5: A write leaves unchanged every mask bit whose data bit is 0. Data bits 6 and 5 have no effect. The mask changes only on a write.
- R6: Read bit 7 is 1 exactly when some flag and its mask bit are both 1. `irq_n` is the inverse of that bit.
- R7: A read (`bus_sel`=1, `bus_wr`=0) presents the current flags and summary bit in that cycle, with bits 6 and 5 always 0. It then clears every flag, and `irq_n` returns to 1 on the next cycle.
- R8: An event pulse in the same cycle as a read is still set in the flags after that read.
- R9: A set-mode write that enables a source whose flag is already pending makes read bit 7 go to 1 and `irq_n` go to 0 in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe for this cycle |
| bus_wr | input | 1 | 1 = mask write, 0 = status read (used with `bus_sel`) |
| bus_wdata | input | 8 | Write data: bit 7 selects set or clear, bits 4..0 select sources |
| bus_rdata | output | 8 | Status: bit 7 summary, bits 6..5 zero, bits 4..0 flags |
| evt_in | input | 5 | One-cycle event pulses, one per source |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench builds the block with its defaults: five sources and an 8-bit data word. At this size all 256 write values are in reach. After each write, the bench probes every mask bit one at a time by firing that source's event and watching `irq_n` and the read value. The small size also lets it walk every set, clear and hold combination against an arithmetic model. The short cases it reaches directly are a pending flag that gets unmasked, an event that coincides with a read, and a reset while flags are pending.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int SRC_COUNT  = 5;
    localparam int WORD_WIDTH = 8;

    typedef enum int {
        SRC_TIMER_A  = 0,
        SRC_TIMER_B  = 1,
        SRC_ALARM    = 2,
        SRC_SERIAL   = 3,
        SRC_FLAG_PIN = 4
    } src_id_t;

    typedef struct packed {
        logic wr;
        logic rd;
    } bus_cmd_t;

    function automatic bus_cmd_t decode_cmd(input logic sel, input logic wr);
        bus_cmd_t c;
        c.wr = sel & wr;
        c.rd = sel & ~wr;
        return c;
    endfunction

    function automatic logic next_mask_bit(input logic cur, input logic pick, input logic set_mode);
        if (!pick) return cur;
        return set_mode;
    endfunction

endpackage

// File: rtl/irqc_flag_bank.sv
module irqc_flag_bank #(
    parameter int NUM_SRC = irqc_pkg::SRC_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr_req,
    input  logic [NUM_SRC-1:0] evt,
    output logic [NUM_SRC-1:0] flags
);

    logic [NUM_SRC-1:0] flags_d;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
            // a coincident event wins over the clearing read
            assign flags_d[i] = evt[i] | (flags[i] & ~clr_req);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= flags_d;
    end

endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
    parameter int NUM_SRC = irqc_pkg::SRC_COUNT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               set_mode,
    input  logic [NUM_SRC-1:0] pick,
    output logic [NUM_SRC-1:0] mask
);

    logic [NUM_SRC-1:0] mask_d;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            assign mask_d[i] = irqc_pkg::next_mask_bit(mask[i], pick[i], set_mode);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)        mask <= '0;
        else if (wr_en) mask <= mask_d;
    end

endmodule

// File: rtl/irqc_req_gen.sv
module irqc_req_gen #(
    parameter int NUM_SRC = irqc_pkg::SRC_COUNT
) (
    input  logic [NUM_SRC-1:0] flags,
    input  logic [NUM_SRC-1:0] mask,
    output logic               req,
    output logic               req_n
);

    assign req   = |(flags & mask);
    assign req_n = ~req;

endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl #(
    parameter int NUM_SRC = irqc_pkg::SRC_COUNT,
    parameter int DATA_W  = irqc_pkg::WORD_WIDTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] evt_in,
    output logic              irq_n
);
    import irqc_pkg::*;

    localparam int MODE_BIT = DATA_W - 1;
    localparam int PAD_W    = DATA_W - 1 - NUM_SRC;

    bus_cmd_t           cmd;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] flags_q;
    logic               req;
    logic               unused_pad;

    assign cmd        = decode_cmd(bus_sel, bus_wr);
    assign unused_pad = ^bus_wdata[MODE_BIT-1:NUM_SRC];

    irqc_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cmd.wr),
        .set_mode (bus_wdata[MODE_BIT]),
        .pick     (bus_wdata[NUM_SRC-1:0]),
        .mask     (mask_q)
    );

    irqc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .clr_req  (cmd.rd),
        .evt      (evt_in),
        .flags    (flags_q)
    );

    irqc_req_gen #(.NUM_SRC(NUM_SRC)) u_req (
        .flags    (flags_q),
        .mask     (mask_q),
        .req      (req),
        .req_n    (irq_n)
    );

    assign bus_rdata = {req, {PAD_W{1'b0}}, flags_q};

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int NUM_SRC = irqc_pkg::SRC_COUNT,
    parameter int DATA_W  = irqc_pkg::WORD_WIDTH
) (
    input logic               clk,
    input logic               rst,
    input logic               sel,
    input logic               wr,
    input logic [DATA_W-1:0]  wdata,
    input logic [DATA_W-1:0]  rdata,
    input logic [NUM_SRC-1:0] evt,
    input logic [NUM_SRC-1:0] mask,
    input logic [NUM_SRC-1:0] flags,
    input logic               irq_n
);

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (irq_n && mask == '0 && flags == '0)); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        !(sel && !wr) |=> ((flags & $past(flags)) == $past(flags))); // R2

    AST_SET_MODE: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && wdata[DATA_W-1]) |=> ((mask & $past(wdata[NUM_SRC-1:0])) == $past(wdata[NUM_SRC-1:0]))); // R3

    AST_CLEAR_MODE: assert property (@(posedge clk) disable iff (rst)
        (sel && wr && !wdata[DATA_W-1]) |=> ((mask & $past(wdata[NUM_SRC-1:0])) == '0)); // R4

    AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (sel && wr) |=> (((mask ^ $past(mask)) & ~$past(wdata[NUM_SRC-1:0])) == '0)); // R5

    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(sel && wr) |=> $stable(mask)); // R5

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> ((flags & mask) != '0)); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (sel && !wr) |=> (flags == $past(evt))); // R7 R8

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        rdata[DATA_W-2:NUM_SRC] == '0); // R7

endmodule

bind irq_mask_ctrl irqc_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .sel   (bus_sel),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .evt   (evt_in),
    .mask  (mask_q),
    .flags (flags_q),
    .irq_n (irq_n)
);

// File: tb/irq_mask_ctrl_bench.sv
module irq_mask_ctrl_bench;
    import irqc_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [4:0] evt_in = 5'b0;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic [4:0] mask_m = 5'b0;

    always #10 clk = ~clk;

    irq_mask_ctrl u_irq_mask_ctrl (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_in(evt_in), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    // read strobe with an optional coincident event; returns value seen in the read cycle
    task automatic do_read(input logic [4:0] ev, output logic [7:0] got);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; evt_in = ev;
        #1 got = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; evt_in = 5'b0;
    endtask

    task automatic pulse(input logic [4:0] ev);
        @(negedge clk);
        evt_in = ev;
        @(negedge clk);
        evt_in = 5'b0;
    endtask

    function automatic logic [4:0] model_write(input logic [4:0] m, input logic [7:0] v);
        if (v[7]) return m | v[4:0];
        return m & ~v[4:0];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);
        check("R1 rdata", bus_rdata, 8'h00);

        // sweep every write value, probe each mask bit through its own event
        for (int w = 0; w < 256; w++) begin
            do_write(w[7:0]);
            mask_m = model_write(mask_m, w[7:0]);
            for (int i = 0; i < 5; i++) begin
                pulse(5'b1 << i);
                check(w[7] ? "R3/R5 R6 irq_n" : "R4/R5 R6 irq_n",
                      {7'b0, irq_n}, {7'b0, ~mask_m[i]});
                do_read(5'b0, rd);
                check("R2 R6 R7 rdata", rd, {mask_m[i], 2'b00, 5'(1 << i)});
                check("R7 cleared", bus_rdata, 8'h00);
                check("R7 irq_n", {7'b0, irq_n}, 8'h01);
            end
        end

        // pending flags while masked, then unmask one
        do_write(8'h1F);
        mask_m = 5'b0;
        pulse(5'b11111);
        check("R2 masked irq_n", {7'b0, irq_n}, 8'h01);
        check("R2 masked flags", bus_rdata, 8'h1F);
        do_write(8'h80 | (8'h1 << SRC_ALARM));
        check("R9 irq_n", {7'b0, irq_n}, 8'h00);
        check("R9 rdata", bus_rdata, 8'h9F);

        // event coincident with a read survives
        do_read(5'b1 << SRC_TIMER_B, rd);
        check("R8 read value", rd, 8'h9F);
        check("R8 kept flag", bus_rdata, 8'h02);
        check("R8 irq_n", {7'b0, irq_n}, 8'h01);
        do_read(5'b0, rd);

        // bits 6 and 5 ignored
        do_write(8'hE0);
        pulse(5'b1 << SRC_FLAG_PIN);
        check("R5 pad bits", {7'b0, irq_n}, 8'h01);
        do_read(5'b0, rd);

        // reset with flags pending and mask set
        do_write(8'h9F);
        pulse(5'b10101);
        check("R6 active before reset", {7'b0, irq_n}, 8'h00);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1 irq_n after reset", {7'b0, irq_n}, 8'h01);
        check("R1 rdata after reset", bus_rdata, 8'h00);
        pulse(5'b1 << SRC_SERIAL);
        check("R1 mask cleared", {7'b0, irq_n}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule